// File: doc/BRIEF.md
# DSI Command Packet Formatter

This block turns one display-link command request into the 32-bit words that a command engine writes to its transmit queue. A request is a six-bit data type, a path select (high-speed or low-power), two parameter bytes and a byte length. A separate valid/ready byte stream carries the payload. The block decides from the data type whether the request is a short packet or a long packet. A short packet becomes one header word. A long packet becomes its payload words first and then one header word that carries the byte count. Words leave on a valid/ready word port. Each word has a flag that marks it as header or payload and a flag that repeats the path select. Writing the header is what starts transmission downstream, so the header is always the last word of a packet.

The control is a four-state machine. `ST_IDLE` accepts requests. On a short type it moves to `ST_HEADER`. On a long type with a non-zero length it moves to `ST_GATHER`. On a rejected request it stays in `ST_IDLE` and raises an error pulse. `ST_GATHER` takes bytes into lanes and moves to `ST_PAYLOAD` when four lanes are filled or the last byte has arrived. `ST_PAYLOAD` offers the packed word. When that word is accepted, the machine returns to `ST_GATHER` if bytes remain, or goes to `ST_HEADER` if none remain. `ST_HEADER` offers the header word and returns to `ST_IDLE` when it is accepted.

Top module: `cmd_pkt_fmt`

## Requirements
- R1: Data types 0x03, 0x13, 0x23, 0x04, 0x14, 0x24, 0x05, 0x15 and 0x06 are short: the request produces exactly one word, a header, and no error pulse.
- R2: Data types 0x29 and 0x39 with a non-zero length are long: the request produces ceil(length/4) payload words followed by one header word, and no error pulse.
- R3: A request with any other data type is dropped. No word is produced, `req_ready` stays high, and `err_pulse` is high for exactly the one cycle after the request is accepted.
- R4: A long request with a length of zero is dropped in the same way as R3, with a one-cycle `err_pulse`.
- R5: A short header word is {8'h00, p1, p0, 2'b00, dtype}: p1 in bits 23:16, p0 in bits 15:8, virtual channel 0 in bits 7:6 and the data type in bits 5:0.
- R6: A long header word is {8'h00, length[15:0], 2'b00, dtype}: the byte count in bits 23:8, virtual channel 0 in bits 7:6 and the data type in bits 5:0.
- R7: Payload bytes are packed little-endian. Stream byte 4k+j lands in bits 8j+7:8j of payload word k.
- R8: When the length is not a multiple of four, the last payload word holds the 1 to 3 leftover bytes in its low lanes, and its unused upper lanes are zero.
- R9: Every payload word has `word_is_hdr` = 0 and is sent before the header. The header has `word_is_hdr` = 1 and is the final word of the packet.
- R10: `word_hs` equals the request's path select on every word of that packet.
- R11: `req_ready` is low from the cycle after a request is accepted until the cycle after its header word is accepted.
- R12: While `word_valid` is high and `word_ready` is low, `word_valid`, `word_data`, `word_is_hdr` and `word_hs` hold their values into the next cycle.
- R13: After reset, `req_ready` is 1 and `word_valid`, `byte_ready` and `err_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_dtype | input | 6 | Packet data type |
| req_hs | input | 1 | Path select: 1 high-speed, 0 low-power |
| req_p0 | input | 8 | Short packet first byte (command or parameter) |
| req_p1 | input | 8 | Short packet second byte |
| req_len | input | LEN_W | Long packet byte length |
| byte_valid | input | 1 | Payload byte offered |
| byte_ready | output | 1 | Payload byte accepted when high with byte_valid |
| byte_data | input | 8 | Payload byte |
| word_valid | output | 1 | Output word offered |
| word_ready | input | 1 | Output word taken when high with word_valid |
| word_data | output | 32 | Output word |
| word_is_hdr | output | 1 | 1 for header word, 0 for payload word |
| word_hs | output | 1 | Path select of the current packet |
| err_pulse | output | 1 | One-cycle pulse for a dropped request |

## Verification
The bench uses the default configuration: a 16-bit length and four byte lanes per word. With these settings the whole data-type space is small enough to cover completely. Every one of the 64 data-type codes is sent, both path selects are used, and each code is checked against the bench's own short/long/rejected list. Long packets are swept over lengths 0 to 13 for both long types, which reaches every tail residue, the zero-length reject and multi-word payloads. Throughout, both the byte stream and the word port stall on fixed rhythms, so that lane filling and output hold are exercised under backpressure.

// File: rtl/pkt_fmt_pkg.sv
package pkt_fmt_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int HLEN_W = 16;

    typedef enum logic [1:0] {
        K_BAD,
        K_SHORT,
        K_LONG
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATHER,
        ST_PAYLOAD,
        ST_HEADER
    } fmt_state_e;
endpackage

// File: rtl/pkt_classify.sv
module pkt_classify
    import pkt_fmt_pkg::*;
(
    input  logic [5:0] dtype,
    output pkt_kind_e  kind
);
    always_comb begin
        case (dtype)
            6'h03, 6'h13, 6'h23,
            6'h04, 6'h14, 6'h24,
            6'h05, 6'h15, 6'h06: kind = K_SHORT;
            6'h29, 6'h39:        kind = K_LONG;
            default:             kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/pkt_hdr_build.sv
module pkt_hdr_build
    import pkt_fmt_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              is_long,
    input  logic [5:0]        dtype,
    input  logic [7:0]        p0,
    input  logic [7:0]        p1,
    input  logic [LEN_W-1:0]  len,
    output logic [WORD_W-1:0] hdr
);
    localparam logic [1:0] VCHAN = 2'b00;

    logic [HLEN_W-1:0] len_field;
    assign len_field = HLEN_W'(len);

    always_comb begin
        if (is_long)
            hdr = {8'h00, len_field, VCHAN, dtype};
        else
            hdr = {8'h00, p1, p0, VCHAN, dtype};
    end
endmodule

// File: rtl/pkt_packer.sv
module pkt_packer
    import pkt_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    output logic              lane_last,
    output logic [WORD_W-1:0] word
);
    localparam int IDX_W = $clog2(LANES);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (clr)
            idx_q <= '0;
        else if (push)
            idx_q <= idx_q + 1'b1;
    end

    assign lane_last = (idx_q == IDX_W'(LANES - 1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (clr)
                lane_q <= '0;
            else if (push && idx_q == IDX_W'(g))
                lane_q <= din;
        end
        assign word[g*BYTE_W +: BYTE_W] = lane_q;
    end
endmodule

// File: rtl/cmd_pkt_fmt.sv
module cmd_pkt_fmt
    import pkt_fmt_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [5:0]       req_dtype,
    input  logic             req_hs,
    input  logic [7:0]       req_p0,
    input  logic [7:0]       req_p1,
    input  logic [LEN_W-1:0] req_len,
    input  logic             byte_valid,
    output logic             byte_ready,
    input  logic [7:0]       byte_data,
    output logic             word_valid,
    input  logic             word_ready,
    output logic [31:0]      word_data,
    output logic             word_is_hdr,
    output logic             word_hs,
    output logic             err_pulse
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    fmt_state_e        state_q, state_d;
    pkt_kind_e         kind;
    logic [WORD_W-1:0] hdr_d, hdr_q, packed_word;
    logic [LEN_W-1:0]  remain_q;
    logic              hs_q, err_q;
    logic              req_fire, byte_fire, word_fire;
    logic              req_bad, lane_last, pk_clr;

    pkt_classify u_cls (
        .dtype (req_dtype),
        .kind  (kind)
    );

    pkt_hdr_build #(.LEN_W(LEN_W)) u_hdr (
        .is_long (kind == K_LONG),
        .dtype   (req_dtype),
        .p0      (req_p0),
        .p1      (req_p1),
        .len     (req_len),
        .hdr     (hdr_d)
    );

    assign req_fire  = req_valid && (state_q == ST_IDLE);
    assign byte_fire = byte_valid && (state_q == ST_GATHER);
    assign word_fire = word_ready &&
                       (state_q == ST_PAYLOAD || state_q == ST_HEADER);
    assign req_bad   = (kind == K_BAD) ||
                       (kind == K_LONG && req_len == '0);
    assign pk_clr    = (state_q == ST_IDLE) ||
                       (state_q == ST_PAYLOAD && word_ready);

    pkt_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pk_clr),
        .push      (byte_fire),
        .din       (byte_data),
        .lane_last (lane_last),
        .word      (packed_word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire && !req_bad)
                    state_d = (kind == K_SHORT) ? ST_HEADER : ST_GATHER;
            end
            ST_GATHER: begin
                if (byte_fire && (lane_last || remain_q == ONE))
                    state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (word_ready)
                    state_d = (remain_q == '0) ? ST_HEADER : ST_GATHER;
            end
            ST_HEADER: begin
                if (word_ready)
                    state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hdr_q    <= '0;
            hs_q     <= 1'b0;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= req_fire && req_bad;
            if (req_fire && !req_bad) begin
                hdr_q    <= hdr_d;
                hs_q     <= req_hs;
                remain_q <= req_len;
            end else if (byte_fire) begin
                remain_q <= remain_q - ONE;
            end
        end
    end

    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        byte_ready  = (state_q == ST_GATHER);
        word_valid  = (state_q == ST_PAYLOAD) || (state_q == ST_HEADER);
        word_is_hdr = (state_q == ST_HEADER);
        word_data   = (state_q == ST_HEADER) ? hdr_q : packed_word;
        word_hs     = hs_q;
        err_pulse   = err_q;
    end

    logic unused_fire;
    assign unused_fire = word_fire;
endmodule

// File: rtl/cmd_pkt_fmt_chk.sv
module cmd_pkt_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        byte_ready,
    input logic        word_valid,
    input logic        word_ready,
    input logic [31:0] word_data,
    input logic        word_is_hdr,
    input logic        word_hs,
    input logic        err_pulse
);
    // R12: stalled word holds
    a_r12_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_ready |=> word_valid && $stable(word_data)
            && $stable(word_is_hdr) && $stable(word_hs));

    // R11: no new request while a word is pending
    a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !req_ready);

    // R3: error pulse only right after an accepted request, never with output
    a_r3_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid && req_ready) && !word_valid);

    // R5/R6: header top byte and virtual channel are zero
    a_r6_hdr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_is_hdr |-> word_data[31:24] == 8'h00
            && word_data[7:6] == 2'b00);

    // R9: gathering and presenting never overlap
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_ready && word_valid));

    // R10: path flag constant across consecutive words
    a_r10_hs_steady: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && $past(word_valid) |-> $stable(word_hs));
endmodule

bind cmd_pkt_fmt cmd_pkt_fmt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .byte_ready  (byte_ready),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .word_data   (word_data),
    .word_is_hdr (word_is_hdr),
    .word_hs     (word_hs),
    .err_pulse   (err_pulse)
);

// File: tb/tb_cmd_pkt_fmt.sv
module tb_cmd_pkt_fmt;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [5:0]       req_dtype = '0;
    logic             req_hs = 1'b0;
    logic [7:0]       req_p0 = '0;
    logic [7:0]       req_p1 = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             byte_valid = 1'b0;
    logic             byte_ready;
    logic [7:0]       byte_data = '0;
    logic             word_valid;
    logic             word_ready = 1'b0;
    logic [31:0]      word_data;
    logic             word_is_hdr;
    logic             word_hs;
    logic             err_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    cmd_pkt_fmt #(.LEN_W(LEN_W)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int k);
        return 8'((k * 37 + seed * 11 + 5) & 8'hFF);
    endfunction

    function automatic logic [31:0] pword(input int seed, input int len, input int w);
        logic [31:0] r = '0;
        for (int j = 0; j < 4; j++)
            if (4 * w + j < len) r[8*j +: 8] = bval(seed, 4 * w + j);
        return r;
    endfunction

    task automatic run_pkt(input logic [5:0] dt, input bit hs, input logic [7:0] p0,
                           input logic [7:0] p1, input int len, input int seed);
        bit is_short, is_long, bad;
        int nwords, got, bi, cyc;
        bit done, stalled;
        logic [31:0] prev, exp;
        is_short = (dt inside {6'h03, 6'h13, 6'h23, 6'h04, 6'h14, 6'h24,
                               6'h05, 6'h15, 6'h06});
        is_long  = (dt == 6'h29 || dt == 6'h39);
        bad      = !is_short && !(is_long && len > 0);
        req_valid = 1'b1; req_dtype = dt; req_hs = hs;
        req_p0 = p0; req_p1 = p1; req_len = LEN_W'(len);
        chk(req_ready == 1'b1, "R11 idle ready", {31'b0, req_ready}, 32'd1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            chk(err_pulse == 1'b1, is_long ? "R4 zero length err" : "R3 unknown err",
                {31'b0, err_pulse}, 32'd1);
            chk(!word_valid && req_ready, "R3 dropped, no word",
                {30'b0, word_valid, req_ready}, 32'd1);
            @(negedge clk);
            chk(err_pulse == 1'b0, "R3 single-cycle err", {31'b0, err_pulse}, 32'd0);
            chk(!word_valid, "R3 no word after drop", {31'b0, word_valid}, 32'd0);
            return;
        end
        chk(err_pulse == 1'b0, is_long ? "R2 long no err" : "R1 short no err",
            {31'b0, err_pulse}, 32'd0);
        nwords = is_long ? (len + 3) / 4 : 0;
        got = 0; bi = 0; cyc = 0; done = 0; stalled = 0; prev = '0;
        while (!done && cyc < 2000) begin
            if (stalled)
                chk(word_valid && word_data == prev, "R12 stall hold", word_data, prev);
            chk(req_ready == 1'b0, "R11 busy", {31'b0, req_ready}, 32'd0);
            if (byte_ready && bi < len && (cyc % 4 != 1)) begin
                byte_valid = 1'b1; byte_data = bval(seed, bi); bi++;
            end else begin
                byte_valid = 1'b0;
            end
            word_ready = (cyc % 3 != 0);
            stalled = word_valid && !word_ready;
            prev = word_data;
            if (word_valid && word_ready) begin
                chk(word_hs == hs, "R10 path flag", {31'b0, word_hs}, {31'b0, hs});
                if (got < nwords) begin
                    exp = pword(seed, len, got);
                    chk(word_is_hdr == 1'b0, "R9 payload flag", {31'b0, word_is_hdr}, 32'd0);
                    chk(word_data == exp,
                        (len % 4 != 0 && got == nwords - 1) ? "R8 tail word" : "R7 payload word",
                        word_data, exp);
                end else begin
                    exp = is_long ? {8'h00, 16'(len), 2'b00, dt}
                                  : {8'h00, p1, p0, 2'b00, dt};
                    chk(word_is_hdr == 1'b1, "R9 header last", {31'b0, word_is_hdr}, 32'd1);
                    chk(word_data == exp, is_long ? "R6 long header" : "R5 short header",
                        word_data, exp);
                    chk(got == nwords, is_long ? "R2 word count" : "R1 single word",
                        32'(got), 32'(nwords));
                    done = 1;
                end
                got++;
            end
            @(posedge clk); @(negedge clk);
            cyc++;
        end
        byte_valid = 1'b0; word_ready = 1'b0;
        chk(done, "R9 packet completes", 32'(done), 32'd1);
        chk(req_ready == 1'b1, "R11 ready after header", {31'b0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !word_valid && !byte_ready && !err_pulse, "R13 reset state",
            {28'b0, req_ready, word_valid, byte_ready, err_pulse}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !word_valid && !byte_ready && !err_pulse, "R13 after release",
            {28'b0, req_ready, word_valid, byte_ready, err_pulse}, 32'h8);
        for (int c = 0; c < 64; c++)
            run_pkt(6'(c), c[0], 8'(c * 3 + 1), 8'(255 - c), 5, c);
        for (int t = 0; t < 2; t++)
            for (int l = 0; l <= 13; l++)
                run_pkt(t == 0 ? 6'h29 : 6'h39, l[1], 8'h00, 8'h00, l, l + 7 * t);
        run_pkt(6'h05, 1'b0, 8'h11, 8'h00, 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule